// File: doc/BRIEF.md
# Console Receive/Transmit Register Window

This peripheral places a character receiver and a character transmitter behind four 32-bit word registers in a reserved window at the top of a 32-bit address space. A processor uses ordinary loads and stores to reach them. On the device side, a keyboard-like source delivers one character per strobe, and a display-like sink takes one character at a time through a valid/take handshake.

Each direction has a control word. Bit 0 of the control word is the ready flag, and the device side sets it. Bit 1 is an interrupt enable that software can write. The receiver control word also has a sticky overrun flag. A load from the receiver data word releases the receiver flag. A store to the transmitter data word claims the transmitter, which stays busy until the sink takes the character. The single interrupt line is raised whenever a ready flag and its enable are both set, so software does not have to spin on the flags.

Read data comes from a register and is returned on the cycle after the access. The interrupt line is also a register output.

Top module: `con_mmio`

## Requirements
- R1: Only word-aligned addresses 0xFFFF0000 + {0, 4, 8, 12} are decoded, as follows: 0 is receiver control, 4 is receiver data, 8 is transmitter control and 12 is transmitter data. Every other address reads as 0, and a store to it has no effect. `bus_rdata` is 0 in any cycle that follows a cycle with no decoded load.
- R2: When `kb_valid` is pulsed, the receiver ready flag (receiver control bit 0) is set and `kb_char` is latched.
- R3: A load from receiver data returns the latched character with zero extension, and it clears the receiver ready flag. If a new character arrives in the same cycle, the flag stays set.
- R4: If a character arrives while the receiver ready flag is still 1 and no receiver data load happens in that cycle, the new character replaces the old one and the overrun bit (receiver control bit 2) is set. The next load from receiver control returns the bit as set and then clears it.
- R5: A store to transmitter data while the transmitter ready flag (transmitter control bit 0) is 1 has three effects: it clears that flag, it drives `scr_valid` high with the store's low 8 bits on `scr_char`, and later loads from transmitter data return that character.
- R6: `scr_take` while `scr_valid` is high drops `scr_valid` and sets the transmitter ready flag again.
- R7: A store to transmitter data while the transmitter ready flag is 0 is dropped, and `scr_char` keeps its value.
- R8: A store to either control word changes only its bit 1 (interrupt enable). The ready bits cannot be written from the bus.
- R9: `irq` is 1 exactly one cycle after a cycle in which (receiver ready AND receiver enable) OR (transmitter ready AND transmitter enable) holds.
- R10: After reset, receiver ready is 0, transmitter ready is 1, both enables are 0, and the overrun bit, `irq`, `scr_valid` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, registered, valid the cycle after the access |
| kb_valid | input | 1 | Device delivers a character this cycle |
| kb_char | input | 8 | Incoming character |
| scr_valid | output | 1 | An outgoing character is waiting for the sink |
| scr_char | output | 8 | Outgoing character |
| scr_take | input | 1 | Sink consumes the waiting character |
| irq | output | 1 | Registered interrupt request |

## Verification
Every state change takes effect at the clock edge that samples the stimulus. Load data and the device-side outputs can be read at the falling edge that follows that edge. `irq` needs one more edge. The bench drives each bus access or device strobe for exactly one cycle starting at a falling edge. It reads `bus_rdata`, `scr_valid` and `scr_char` at the next falling edge, and it waits one extra falling edge before it reads `irq`. The sweeps cover all 256 character values in both directions and every byte address in the window, plus aliasing addresses outside it.

// File: rtl/con_pkg.sv
package con_pkg;
  // Word index inside the window (address bits [3:2]); order fixed by the map
  typedef enum logic [1:0] {
    IDX_RX_CTRL = 2'd0,
    IDX_RX_DATA = 2'd1,
    IDX_TX_CTRL = 2'd2,
    IDX_TX_DATA = 2'd3
  } con_idx_e;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned BIT_RDY  = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_OVR  = 2;
endpackage

// File: rtl/con_decode.sv
module con_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [31:0] BASE     = 32'hFFFF0000,
  parameter int unsigned WIN_BITS = 4
) (
  input  logic                         sel,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  output logic [con_pkg::NUM_REGS-1:0] rd_hit,
  output logic [con_pkg::NUM_REGS-1:0] wr_hit
);
  localparam int unsigned IDX_W = WIN_BITS - 2;

  logic             in_win;
  logic [IDX_W-1:0] idx;

  assign in_win = sel
                  && (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS])
                  && (addr[1:0] == 2'b00);
  assign idx = addr[WIN_BITS-1:2];

  for (genvar g = 0; g < con_pkg::NUM_REGS; g++) begin : g_hit
    assign rd_hit[g] = in_win && !we && (idx == IDX_W'(g));
    assign wr_hit[g] = in_win &&  we && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/con_rx_chan.sv
module con_rx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_valid,
  input  logic [CHAR_W-1:0] dev_char,
  input  logic              ld_data,
  input  logic              ld_ctrl,
  input  logic              st_ctrl,
  input  logic              st_ie,
  output logic              rdy,
  output logic              ie,
  output logic              ovr,
  output logic [CHAR_W-1:0] chr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy <= 1'b0;
      ie  <= 1'b0;
      ovr <= 1'b0;
      chr <= '0;
    end else begin
      // arrival beats the clearing load
      if (dev_valid) begin
        chr <= dev_char;
        rdy <= 1'b1;
      end else if (ld_data) begin
        rdy <= 1'b0;
      end
      // setting the overrun bit beats the clearing read
      if (dev_valid && rdy && !ld_data) begin
        ovr <= 1'b1;
      end else if (ld_ctrl) begin
        ovr <= 1'b0;
      end
      if (st_ctrl) begin
        ie <= st_ie;
      end
    end
  end
endmodule

// File: rtl/con_tx_chan.sv
module con_tx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_data,
  input  logic [CHAR_W-1:0] st_char,
  input  logic              st_ctrl,
  input  logic              st_ie,
  input  logic              dev_take,
  output logic              rdy,
  output logic              ie,
  output logic              pend,
  output logic [CHAR_W-1:0] chr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy  <= 1'b1;
      ie   <= 1'b0;
      pend <= 1'b0;
      chr  <= '0;
    end else begin
      if (pend && dev_take) begin
        pend <= 1'b0;
        rdy  <= 1'b1;
      end else if (st_data && rdy) begin
        chr  <= st_char;
        pend <= 1'b1;
        rdy  <= 1'b0;
      end
      if (st_ctrl) begin
        ie <= st_ie;
      end
    end
  end
endmodule

// File: rtl/con_mmio.sv
module con_mmio #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CHAR_W   = 8,
  parameter logic [31:0] BASE     = 32'hFFFF0000,
  parameter int unsigned WIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_char,
  output logic              scr_valid,
  output logic [CHAR_W-1:0] scr_char,
  input  logic              scr_take,
  output logic              irq
);
  import con_pkg::*;

  logic [NUM_REGS-1:0] rd_hit, wr_hit;
  logic                rx_rdy, rx_ie, rx_ovr;
  logic [CHAR_W-1:0]   rx_chr;
  logic                tx_rdy, tx_ie;
  logic [DATA_W-1:0]   rd_mux;
  logic                irq_d;

  con_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_BITS(WIN_BITS)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  con_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst(rst),
    .dev_valid(kb_valid), .dev_char(kb_char),
    .ld_data(rd_hit[IDX_RX_DATA]), .ld_ctrl(rd_hit[IDX_RX_CTRL]),
    .st_ctrl(wr_hit[IDX_RX_CTRL]), .st_ie(bus_wdata[BIT_IE]),
    .rdy(rx_rdy), .ie(rx_ie), .ovr(rx_ovr), .chr(rx_chr)
  );

  con_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst),
    .st_data(wr_hit[IDX_TX_DATA]), .st_char(bus_wdata[CHAR_W-1:0]),
    .st_ctrl(wr_hit[IDX_TX_CTRL]), .st_ie(bus_wdata[BIT_IE]),
    .dev_take(scr_take),
    .rdy(tx_rdy), .ie(tx_ie), .pend(scr_valid), .chr(scr_char)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_hit[IDX_RX_CTRL]) begin
      rd_mux[BIT_RDY] = rx_rdy;
      rd_mux[BIT_IE]  = rx_ie;
      rd_mux[BIT_OVR] = rx_ovr;
    end
    if (rd_hit[IDX_RX_DATA]) rd_mux[CHAR_W-1:0] = rx_chr;
    if (rd_hit[IDX_TX_CTRL]) begin
      rd_mux[BIT_RDY] = tx_rdy;
      rd_mux[BIT_IE]  = tx_ie;
    end
    if (rd_hit[IDX_TX_DATA]) rd_mux[CHAR_W-1:0] = scr_char;
  end

  assign irq_d = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq       <= irq_d;
    end
  end
endmodule

// File: rtl/con_mmio_chk.sv
module con_mmio_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kb_valid,
  input logic              scr_valid,
  input logic [CHAR_W-1:0] scr_char,
  input logic              scr_take,
  input logic              irq,
  input logic              rx_rdy,
  input logic              rx_ie,
  input logic              tx_rdy,
  input logic              tx_ie
);
  logic want_irq;
  assign want_irq = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);

  // R1
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (bus_rdata == '0));

  // R2
  rx_arrival_sets_chk: assert property (@(posedge clk) disable iff (rst)
    kb_valid |=> rx_rdy);

  // R6
  take_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (scr_valid && scr_take) |=> (!scr_valid && tx_rdy));

  // R7
  pending_char_held_chk: assert property (@(posedge clk) disable iff (rst)
    (scr_valid && !scr_take) |=> $stable(scr_char));

  // R5
  tx_busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    scr_valid |-> !tx_rdy);

  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (irq == $past(want_irq)));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !scr_valid && bus_rdata == '0));
endmodule

bind con_mmio con_mmio_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rdata(bus_rdata),
  .kb_valid(kb_valid), .scr_valid(scr_valid), .scr_char(scr_char),
  .scr_take(scr_take), .irq(irq),
  .rx_rdy(rx_rdy), .rx_ie(rx_ie), .tx_rdy(tx_rdy), .tx_ie(tx_ie)
);

// File: tb/sim_con_mmio.sv
module sim_con_mmio;
  localparam int CLK_P = 10;
  localparam logic [31:0] B = 32'hFFFF0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_char = '0;
  logic        scr_valid, scr_take = 1'b0, irq;
  logic [7:0]  scr_char;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  con_mmio u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_char(kb_char), .scr_valid(scr_valid),
    .scr_char(scr_char), .scr_take(scr_take), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic kb(input logic [7:0] c);
    @(negedge clk);
    kb_valid = 1'b1; kb_char = c;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    scr_take = 1'b1;
    @(negedge clk);
    scr_take = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 irq", {31'b0, irq}, 32'd0);
    check("R10 scr_valid", {31'b0, scr_valid}, 32'd0);
    check("R10 rdata", bus_rdata, 32'd0);
    rd(B + 0, v);  check("R10 rx ctrl", v, 32'd0);
    rd(B + 8, v);  check("R10 tx ctrl", v, 32'd1);
    rd(B + 4, v);  check("R10 rx data", v, 32'd0);

    // R1 sweep of every byte address in the window
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      e = ((i % 4) == 0 && i == 8) ? 32'd1 : 32'd0;
      rd(B + i, v);
      check($sformatf("R1 window byte %0d", i), v, e);
    end
    // R1 addresses outside the window, including aliases of the data words
    rd(32'hFFFF0018, v); check("R1 above window", v, 32'd0);
    rd(32'hFFFE0008, v); check("R1 below base", v, 32'd0);
    rd(32'h00000008, v); check("R1 low alias", v, 32'd0);
    wr(32'hFFFF001C, 32'h41);
    check("R1 alias store ignored", {31'b0, scr_valid}, 32'd0);
    wr(32'hFFFE000C, 32'h41);
    wr(B + 13, 32'h41);
    check("R1 misaligned store ignored", {31'b0, scr_valid}, 32'd0);
    rd(B + 8, v); check("R1 tx still ready", v, 32'd1);

    // R2/R3 sweep over all characters
    for (int c = 0; c < 256; c++) begin
      kb(8'(c));
      rd(B + 0, v); check($sformatf("R2 rx ready c=%0d", c), v, 32'd1);
      rd(B + 4, v); check($sformatf("R3 rx data c=%0d", c), v, 32'(c));
      rd(B + 0, v); check($sformatf("R3 rx cleared c=%0d", c), v, 32'd0);
    end

    // R4 overrun
    kb(8'h11);
    kb(8'h22);
    rd(B + 0, v); check("R4 overrun flagged", v, 32'd5);
    rd(B + 0, v); check("R4 overrun cleared by ctrl read", v, 32'd1);
    rd(B + 4, v); check("R4 newer char kept", v, 32'h22);
    rd(B + 0, v); check("R4 idle after", v, 32'd0);

    // R5/R6/R7 sweep over all characters
    for (int c = 0; c < 256; c++) begin
      wr(B + 12, 32'hABCDEF00 | 32'(c));
      check($sformatf("R5 scr_valid c=%0d", c), {31'b0, scr_valid}, 32'd1);
      check($sformatf("R5 scr_char c=%0d", c), {24'b0, scr_char}, 32'(c));
      rd(B + 8, v); check($sformatf("R5 tx busy c=%0d", c), v, 32'd0);
      wr(B + 12, 32'(8'(c) ^ 8'hFF));
      check($sformatf("R7 store dropped c=%0d", c), {24'b0, scr_char}, 32'(c));
      take();
      check($sformatf("R6 scr_valid low c=%0d", c), {31'b0, scr_valid}, 32'd0);
      rd(B + 8, v);  check($sformatf("R6 tx ready c=%0d", c), v, 32'd1);
      rd(B + 12, v); check($sformatf("R5 tx data readback c=%0d", c), v, 32'(c));
    end

    // R8 control writes touch only the enable bit
    wr(B + 0, 32'hFFFFFFFF);
    rd(B + 0, v); check("R8 rx ctrl only ie", v, 32'd2);
    wr(B + 8, 32'hFFFFFFFC);
    rd(B + 8, v); check("R8 tx ready not writable", v, 32'd1);

    // R9 interrupt: rx enabled but not ready, tx disabled
    @(negedge clk);
    check("R9 no irq", {31'b0, irq}, 32'd0);
    wr(B + 8, 32'd2);
    @(negedge clk);
    check("R9 tx irq", {31'b0, irq}, 32'd1);
    wr(B + 8, 32'd0);
    @(negedge clk);
    check("R9 tx irq off", {31'b0, irq}, 32'd0);
    kb(8'h5A);
    @(negedge clk);
    check("R9 rx irq", {31'b0, irq}, 32'd1);
    rd(B + 4, v); check("R3 data under irq", v, 32'h5A);
    @(negedge clk);
    check("R9 rx irq cleared", {31'b0, irq}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule